// File: doc/BRIEF.md
# Configurable Sequential Logic Macrocell

This block is one programmable logic cell of the sum-of-products kind. An input vector and one feedback signal feed a programmable AND plane. Each product term there can take the true form, the complemented form, or neither form of every array input. The OR of all product terms forms the cell's logic sum. Configuration inputs then set what happens to that sum:

- It can drive the pin directly, or go through a flip-flop that captures on a selectable clock edge.
- The flip-flop has a clear and a preset, each gated by its own enable.
- The pin value can be inverted.
- The pin driver has its own enable.
- The feedback into the array comes either from the flip-flop or from the pad.

All configuration arrives on plain input ports and is expected to be static while the cell is in use. A single instance can therefore act as a decoder, a registered state bit, a toggle cell or an input buffer, depending only on its configuration bits. Routing between cells and the loading of configuration are outside this block.

Top module: `pld_macrocell`

## Requirements
- R1: Array input j is `in_vec[j]` for j below N_IN, and the feedback signal for j = N_IN. Product term p uses bit `p*2*(N_IN+1) + 2*j` of `and_cfg` to require input j high, and bit `+1` above it to require input j low. The term is the AND of every literal it requires, so a term that requires both forms of one input is always 0.
- R2: A product term with no configuration bit set evaluates to 0. With all of `and_cfg` clear, the logic sum is 0 for every input value.
- R3: The logic sum is the OR of all N_PT product terms.
- R4: With `opt_registered` low, `pin_out` follows the logic sum combinationally, with no clock edge in between.
- R5: The flip-flop captures the logic sum on the rising clock edge when `opt_neg_edge` is 0, and on the falling edge when it is 1. It holds its value across the other edge. With `opt_registered` high, `pin_out` shows the flip-flop.
- R6: With `opt_clr_en` high, a high `async_clr` forces the flip-flop to 0 at once, without waiting for a clock edge. The clear wins over an active preset.
- R7: With `opt_pre_en` high, a high `async_pre` forces the flip-flop to 1 at once. When its enable is low, `async_pre` or `async_clr` has no effect.
- R8: `opt_invert` complements `pin_out` in both output modes. `fb_out` always carries the value before the inversion.
- R9: `pin_oe` equals `opt_oe`.
- R10: `fb_out` (array input N_IN) is the flip-flop output when `opt_fb_from_pin` is 0, and `pin_in` when it is 1.
- R11: A high `rst` clears the flip-flop at its active clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| in_vec | input | N_IN | Array inputs |
| pin_in | input | 1 | Value seen at the pad |
| and_cfg | input | N_PT*2*(N_IN+1) | AND-plane connection bits |
| opt_registered | input | 1 | 1: pin shows the flip-flop, 0: pin shows the logic sum |
| opt_neg_edge | input | 1 | 1: capture on the falling edge |
| opt_clr_en | input | 1 | Enables the asynchronous clear |
| opt_pre_en | input | 1 | Enables the asynchronous preset |
| opt_invert | input | 1 | Inverts the pin value |
| opt_oe | input | 1 | Pin driver enable |
| opt_fb_from_pin | input | 1 | 1: feedback from pad, 0: from flip-flop |
| async_clr | input | 1 | Asynchronous clear request |
| async_pre | input | 1 | Asynchronous preset request |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback signal, also array input N_IN |

## Verification
Feedback exposes the flip-flop at the ports in every mode, so a wrong stored bit shows on `fb_out` right after the active edge, or right after the clear or preset acts. A wrong AND-plane connection shows on `pin_out` in combinational mode in the same cycle, for the minterm that the faulty literal touches. Sweeping all sixteen input values of two known four-input functions reaches every such minterm. Capturing on the wrong edge shows half a cycle early or late, and the bench samples on both sides of each edge to catch it.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef struct packed {
    logic reg_mode;
    logic neg_edge;
    logic clr_en;
    logic pre_en;
    logic invert;
    logic oe;
    logic fb_pin;
  } mc_opts_t;
endpackage

// File: rtl/pld_and_term.sv
module pld_and_term #(
  parameter int W = 5
) (
  input  logic [2*W-1:0] conn,
  input  logic [W-1:0]   x,
  output logic           term
);
  logic all_ok;

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (conn[2*i] && !x[i])   all_ok = 1'b0;
      if (conn[2*i+1] && x[i])  all_ok = 1'b0;
    end
    // a term with no literal is treated as unused
    term = all_ok && (|conn);
  end
endmodule

// File: rtl/pld_and_or_plane.sv
module pld_and_or_plane #(
  parameter int W    = 5,
  parameter int N_PT = 8
) (
  input  logic [N_PT*2*W-1:0] cfg,
  input  logic [W-1:0]        x,
  output logic                sop
);
  localparam int TW = 2 * W;

  logic [N_PT-1:0] terms;

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    pld_and_term #(.W(W)) u_term (
      .conn (cfg[p*TW +: TW]),
      .x    (x),
      .term (terms[p])
    );
  end

  assign sop = |terms;
endmodule

// File: rtl/pld_mc_reg.sv
module pld_mc_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic clr_a,
  input  logic pre_a,
  input  logic neg_sel,
  output logic q
);
  logic q_pos;
  logic q_neg;

  always_ff @(posedge clk or posedge clr_a or posedge pre_a) begin
    if (clr_a)      q_pos <= 1'b0;
    else if (pre_a) q_pos <= 1'b1;
    else if (rst)   q_pos <= 1'b0;
    else            q_pos <= d;
  end

  always_ff @(negedge clk or posedge clr_a or posedge pre_a) begin
    if (clr_a)      q_neg <= 1'b0;
    else if (pre_a) q_neg <= 1'b1;
    else if (rst)   q_neg <= 1'b0;
    else            q_neg <= d;
  end

  assign q = neg_sel ? q_neg : q_pos;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int N_IN = 4,
  parameter int N_PT = 8,
  localparam int W     = N_IN + 1,
  localparam int CFG_W = N_PT * 2 * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  in_vec,
  input  logic             pin_in,
  input  logic [CFG_W-1:0] and_cfg,
  input  logic             opt_registered,
  input  logic             opt_neg_edge,
  input  logic             opt_clr_en,
  input  logic             opt_pre_en,
  input  logic             opt_invert,
  input  logic             opt_oe,
  input  logic             opt_fb_from_pin,
  input  logic             async_clr,
  input  logic             async_pre,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  import pld_mc_pkg::*;

  mc_opts_t opts;
  logic     sop;
  logic     q;
  logic     clr_g;
  logic     pre_g;
  logic     core;
  logic [W-1:0] arr_x;

  assign opts = '{reg_mode: opt_registered, neg_edge: opt_neg_edge,
                  clr_en: opt_clr_en, pre_en: opt_pre_en,
                  invert: opt_invert, oe: opt_oe, fb_pin: opt_fb_from_pin};

  assign arr_x = {fb_out, in_vec};

  pld_and_or_plane #(.W(W), .N_PT(N_PT)) u_plane (
    .cfg (and_cfg),
    .x   (arr_x),
    .sop (sop)
  );

  assign clr_g = async_clr & opts.clr_en;
  assign pre_g = async_pre & opts.pre_en;

  pld_mc_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .d       (sop),
    .clr_a   (clr_g),
    .pre_a   (pre_g),
    .neg_sel (opts.neg_edge),
    .q       (q)
  );

  assign core    = opts.reg_mode ? q : sop;
  assign pin_out = core ^ opts.invert;
  assign pin_oe  = opts.oe;
  assign fb_out  = opts.fb_pin ? pin_in : q;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int CFG_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] and_cfg,
  input logic             opt_neg_edge,
  input logic             opt_fb_from_pin,
  input logic             opt_clr_en,
  input logic             opt_pre_en,
  input logic             async_clr,
  input logic             async_pre,
  input logic             sop,
  input logic             fb_out
);
  logic clr_on;
  logic pre_on;
  assign clr_on = async_clr && opt_clr_en;
  assign pre_on = async_pre && opt_pre_en;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr_on && !opt_fb_from_pin) |-> (fb_out == 1'b0)); // R6

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst)
    (pre_on && !clr_on && !opt_fb_from_pin) |-> (fb_out == 1'b1)); // R7

  AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!opt_neg_edge && !clr_on && !pre_on && !opt_fb_from_pin) |=>
    ((fb_out == $past(sop)) || opt_neg_edge || opt_fb_from_pin || clr_on || pre_on)); // R5

  AST_FALL_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    (opt_neg_edge && !clr_on && !pre_on && !opt_fb_from_pin) |=>
    ((fb_out == $past(sop)) || !opt_neg_edge || opt_fb_from_pin || clr_on || pre_on)); // R5

  AST_EMPTY_PLANE: assert property (@(posedge clk) disable iff (rst)
    (and_cfg == '0) |-> !sop); // R2
endmodule

bind pld_macrocell pld_macrocell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .and_cfg         (and_cfg),
  .opt_neg_edge    (opt_neg_edge),
  .opt_fb_from_pin (opt_fb_from_pin),
  .opt_clr_en      (opt_clr_en),
  .opt_pre_en      (opt_pre_en),
  .async_clr       (async_clr),
  .async_pre       (async_pre),
  .sop             (sop),
  .fb_out          (fb_out)
);

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  localparam int N_IN  = 4;
  localparam int N_PT  = 8;
  localparam int W     = N_IN + 1;
  localparam int CFG_W = N_PT * 2 * W;
  localparam logic [15:0] Z_MASK = 16'h3106; // minterms 1,2,8,12,13
  localparam logic [15:0] Y_MASK = 16'h8DFD; // minterms 0,2-8,10,11,15

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] in_vec = '0;
  logic pin_in = 1'b0;
  logic [CFG_W-1:0] and_cfg = '0;
  logic opt_registered = 0, opt_neg_edge = 0, opt_clr_en = 0, opt_pre_en = 0;
  logic opt_invert = 0, opt_oe = 0, opt_fb_from_pin = 0;
  logic async_clr = 0, async_pre = 0;
  logic pin_out, pin_oe, fb_out;

  always #5 clk = ~clk;

  pld_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) u_pld_macrocell (
    .clk(clk), .rst(rst), .in_vec(in_vec), .pin_in(pin_in), .and_cfg(and_cfg),
    .opt_registered(opt_registered), .opt_neg_edge(opt_neg_edge),
    .opt_clr_en(opt_clr_en), .opt_pre_en(opt_pre_en), .opt_invert(opt_invert),
    .opt_oe(opt_oe), .opt_fb_from_pin(opt_fb_from_pin),
    .async_clr(async_clr), .async_pre(async_pre),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // scoreboard item: expected {pin_out, pin_oe, fb_out} and which bits matter
  typedef struct {
    string      req;
    logic [2:0] exp;
    logic [2:0] care;
  } sb_item_t;

  sb_item_t sbq[$];
  event     sample_ev;
  int       n_cmp = 0;
  int       n_bad = 0;
  bit       done  = 0;

  task automatic expect_now(string req, logic [2:0] exp, logic [2:0] care);
    sb_item_t it;
    it.req = req; it.exp = exp; it.care = care;
    sbq.push_back(it);
    -> sample_ev;
    #0;
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sbq.size() > 0) begin
        sb_item_t it;
        logic [2:0] act;
        it  = sbq.pop_front();
        act = {pin_out, pin_oe, fb_out};
        n_cmp++;
        if ((act & it.care) !== (it.exp & it.care)) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b (care %b) at %0t",
                   it.req, act, it.exp, it.care, $time);
        end
      end
    end
  end

  task automatic drive_slot();
    @(posedge clk); #2;
  endtask

  task automatic lit(int p, int i, bit comp);
    and_cfg[p*2*W + 2*i + int'(comp)] = 1'b1;
  endtask

  task automatic prog_minterm(int p, logic [3:0] m);
    for (int i = 0; i < 4; i++) lit(p, i, !m[i]);
  endtask

  task automatic prog_z();
    and_cfg = '0;
    prog_minterm(0, 4'd1); prog_minterm(1, 4'd2); prog_minterm(2, 4'd8);
    prog_minterm(3, 4'd12); prog_minterm(4, 4'd13);
  endtask

  task automatic prog_y();
    and_cfg = '0;
    lit(0, 3, 1); lit(0, 2, 0);  // A'B
    lit(1, 1, 0); lit(1, 0, 0);  // CD
    lit(2, 2, 1); lit(2, 0, 1);  // B'D'
  endtask

  initial begin
    logic prev;
    repeat (3) @(posedge clk);
    #2;
    expect_now("R11 reset state", 3'b000, 3'b111);
    rst = 1'b0;

    // R2: empty plane
    for (int v = 0; v < 16; v += 5) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R2 empty plane", 3'b000, 3'b100);
    end

    // R1: both forms of one input required -> term never true
    drive_slot(); and_cfg = '0; lit(0, 0, 0); lit(0, 0, 1);
    for (int v = 0; v < 2; v++) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R1 contradictory term", 3'b000, 3'b100);
    end

    // R1 R3 R4: minterm function, combinational
    drive_slot(); prog_z();
    for (int v = 0; v < 16; v++) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R4 comb z", {Z_MASK[v], 2'b00}, 3'b100);
    end

    // R3 with shared-literal terms
    drive_slot(); prog_y();
    for (int v = 0; v < 16; v++) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R3 comb y", {Y_MASK[v], 2'b00}, 3'b100);
    end

    // R8 inversion in combinational mode
    drive_slot(); opt_invert = 1'b1;
    for (int v = 0; v < 16; v += 3) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R8 comb invert", {~Y_MASK[v], 2'b00}, 3'b100);
    end

    // R5 rising edge, registered, inverted pin
    drive_slot(); prog_z(); opt_registered = 1'b1; in_vec = 4'd0;
    @(posedge clk); #1;
    prev = Z_MASK[0];
    for (int v = 0; v < 16; v++) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R5 hold before rise", {~prev, 1'b0, prev}, 3'b101);
      @(negedge clk); #1;
      expect_now("R5 hold over fall", {~prev, 1'b0, prev}, 3'b101);
      @(posedge clk); #1;
      expect_now("R8 rise capture", {~Z_MASK[v], 1'b0, Z_MASK[v]}, 3'b101);
      prev = Z_MASK[v];
    end

    // R5 falling edge
    drive_slot(); opt_neg_edge = 1'b1; opt_invert = 1'b0;
    @(posedge clk); #1;
    for (int v = 15; v >= 0; v--) begin
      drive_slot(); in_vec = 4'(v); #1;
      expect_now("R5 hold before fall", {prev, 1'b0, prev}, 3'b101);
      @(negedge clk); #1;
      expect_now("R5 fall capture", {Z_MASK[v], 1'b0, Z_MASK[v]}, 3'b101);
      @(posedge clk); #1;
      expect_now("R5 hold over rise", {Z_MASK[v], 1'b0, Z_MASK[v]}, 3'b101);
      prev = Z_MASK[v];
    end

    // R6 clear, and its priority over preset
    drive_slot(); opt_neg_edge = 1'b0; in_vec = 4'd1;
    @(posedge clk); #1;
    expect_now("R6 setup", 3'b101, 3'b101);
    drive_slot(); opt_clr_en = 1'b1; async_clr = 1'b1; #1;
    expect_now("R6 immediate clear", 3'b000, 3'b101);
    @(posedge clk); #1;
    expect_now("R6 clear held", 3'b000, 3'b101);
    drive_slot(); opt_pre_en = 1'b1; async_pre = 1'b1; #1;
    expect_now("R6 clear beats preset", 3'b000, 3'b101);
    @(posedge clk); #1;
    expect_now("R6 clear beats preset edge", 3'b000, 3'b101);
    drive_slot(); async_clr = 1'b0; async_pre = 1'b0;
    @(posedge clk); #1;
    expect_now("R6 release recapture", 3'b101, 3'b101);

    // R7 preset
    drive_slot(); in_vec = 4'd0;
    @(posedge clk); #1;
    drive_slot(); async_pre = 1'b1; #1;
    expect_now("R7 immediate preset", 3'b101, 3'b101);
    @(posedge clk); #1;
    expect_now("R7 preset held", 3'b101, 3'b101);
    drive_slot(); async_pre = 1'b0;
    @(posedge clk); #1;
    expect_now("R7 preset release", 3'b000, 3'b101);

    // R7 disabled controls have no effect
    drive_slot(); opt_pre_en = 1'b0; opt_clr_en = 1'b0; async_pre = 1'b1; #1;
    expect_now("R7 preset disabled", 3'b000, 3'b101);
    @(posedge clk); #1;
    expect_now("R7 preset disabled edge", 3'b000, 3'b101);
    drive_slot(); in_vec = 4'd1;
    @(posedge clk); #1;
    drive_slot(); async_clr = 1'b1; #1;
    expect_now("R7 clear disabled", 3'b101, 3'b101);
    @(posedge clk); #1;
    expect_now("R7 clear disabled edge", 3'b101, 3'b101);
    drive_slot(); async_clr = 1'b0; async_pre = 1'b0;

    // R9 pin enable
    drive_slot(); opt_oe = 1'b1; #1;
    expect_now("R9 oe on", 3'b010, 3'b010);
    drive_slot(); opt_oe = 1'b0; #1;
    expect_now("R9 oe off", 3'b000, 3'b010);

    // R10 feedback from pad, used as an input
    drive_slot(); opt_registered = 1'b0; opt_fb_from_pin = 1'b1;
    and_cfg = '0; lit(0, N_IN, 0); pin_in = 1'b1; #1;
    expect_now("R10 pad feedback high", 3'b101, 3'b101);
    drive_slot(); pin_in = 1'b0; #1;
    expect_now("R10 pad feedback low", 3'b000, 3'b101);
    drive_slot(); and_cfg = '0; lit(0, N_IN, 1); #1;
    expect_now("R10 pad feedback inverted literal", 3'b100, 3'b101);

    // R10 register feedback: toggle cell
    drive_slot(); opt_fb_from_pin = 1'b0; opt_registered = 1'b1;
    opt_clr_en = 1'b1; async_clr = 1'b1;
    @(posedge clk);
    drive_slot(); async_clr = 1'b0; #1;
    expect_now("R10 toggle start", 3'b000, 3'b101);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      expect_now("R10 toggle step", {~k[0], 1'b0, ~k[0]}, 3'b101);
    end

    // R11 synchronous reset of the register
    drive_slot(); prog_z(); in_vec = 4'd1; opt_clr_en = 1'b0;
    @(posedge clk); #1;
    expect_now("R11 pre-reset value", 3'b101, 3'b101);
    drive_slot(); rst = 1'b1; #1;
    expect_now("R11 no effect before edge", 3'b101, 3'b101);
    @(posedge clk); #1;
    expect_now("R11 reset at edge", 3'b000, 3'b101);
    drive_slot(); rst = 1'b0;

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule